// File: doc/BRIEF.md
# Add-One Carry Select Adder

This block adds two N-bit operands and a carry-in. It returns an N-bit sum and a carry-out, and it has no clock or storage. The operand bits are divided into groups. The lowest group is a ripple-carry adder fed by the true carry-in. Every higher group runs one ripple-carry adder that assumes a group carry of zero. An increment network derives the result for a group carry of one from that sum. A two-way selector per group then chooses between the two results once the real carry from the group below arrives.

The group widths are a compile-time list. Equal widths give a linear layout. Widths that grow toward the most significant end give a square-root layout, which balances the ripple time inside a group against the number of selectors on the carry chain. The same parameterisation serves 8-, 16-, 32- and 64-bit adders. The block has no clocked logic, so it has no state machine, no states and no transitions.

Top module: `csa_bec_adder`

## Requirements
- R1: For every input, `{carry_o, sum_o}` equals `op_a + op_b + carry_i`, computed with N+1 bits.
- R2: The least significant group is a plain ripple-carry adder driven directly by `carry_i`, with no select stage.
- R3: The increment network of a group of width W returns its W-bit input plus one, modulo 2^W, using an AND-prefix chain: bit k is inverted when all bits below k are one.
- R4: A group's carry-out under an assumed carry-in of one is the carry-out under zero OR the AND of all zero-assumed sum bits.
- R5: Each select group outputs its zero-assumed sum and carry when the real carry into it is 0, and the incremented sum and carry when that carry is 1.
- R6: The group widths are packed 8 bits per group in `GRP_SIZES`, with group 0 (least significant) in bits [7:0]. A list whose widths do not add up to N is rejected at elaboration.
- R7: A uniform and a square-root width list for the same N give identical results for identical inputs.
- R8: A carry produced in the lowest bit travels across every group boundary (all-ones operand plus one) into `carry_o`.
- R9: The structure works unchanged at 8, 32 and 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | N | First addend |
| op_b | input | N | Second addend |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Sum bits |
| carry_o | output | 1 | Carry out of bit N-1 |

## Verification
An 8-bit build with widths 2/3/3 is driven through every operand and carry-in combination. This shows that each selector and each increment network is correct for every input. Random operands on 16-, 32- and 64-bit builds, in both uniform and square-root layouts, cover the wide carry chains. Directed vectors are added where random operands rarely land: all-ones plus one, carries that stop exactly at one group boundary, and a group whose zero-assumed sum is all ones while its carry-in is one. These tell a wrong selector polarity apart from a wrong increment carry and from a mis-placed group offset.

// File: rtl/csa_pkg.sv
package csa_pkg;
    localparam int unsigned MAX_GROUPS = 64;

    // Lowest bit index of group idx: sum of the widths of all groups below it.
    function automatic int unsigned grp_off(input logic [8*MAX_GROUPS-1:0] sizes,
                                            input int unsigned idx);
        int unsigned acc;
        acc = 0;
        for (int unsigned k = 0; k < MAX_GROUPS; k++) begin
            if (k < idx) acc += int'(sizes[8*k +: 8]);
        end
        return acc;
    endfunction
endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    always_comb begin
        logic c;
        c = ci;
        for (int i = 0; i < W; i++) begin
            s[i] = a[i] ^ b[i] ^ c;
            c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
        end
        co = c;
    end

    always_comb begin : chk
        if (!$isunknown({a, b, ci, s, co})) begin
            a_r2_ripple_sum: assert ({co, s} == {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci})
                else $error("R2 ripple group sum wrong");
        end
    end
endmodule

// File: rtl/csa_plus_one.sv
module csa_plus_one #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y,
    output logic         all_ones
);
    always_comb begin
        logic run;
        run = 1'b1;
        for (int i = 0; i < W; i++) begin
            y[i] = x[i] ^ run;
            run  = run & x[i];
        end
        all_ones = run;
    end

    always_comb begin : chk
        if (!$isunknown({x, y})) begin
            a_r3_plus_one: assert (y == x + W'(1))
                else $error("R3 increment network wrong");
        end
    end
endmodule

// File: rtl/csa_sel_group.sv
module csa_sel_group #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W-1:0] s_zero, s_one;
    logic         c_zero, c_one, zs_full;

    csa_ripple #(.W(W)) u_rca (
        .a(a), .b(b), .ci(1'b0), .s(s_zero), .co(c_zero)
    );

    csa_plus_one #(.W(W)) u_inc (
        .x(s_zero), .y(s_one), .all_ones(zs_full)
    );

    assign c_one = c_zero | zs_full;

    always_comb begin
        unique case (ci)
            1'b0:    {co, s} = {c_zero, s_zero};
            default: {co, s} = {c_one, s_one};
        endcase
    end

    always_comb begin : chk
        if (!$isunknown({a, b, ci, s, co, s_zero, c_zero, c_one, s_one})) begin
            a_r4_carry_one: assert ({c_one, s_one} == {c_zero, s_zero} + (W+1)'(1))
                else $error("R4 carry under assumed one wrong");
            a_r5_select: assert ({co, s} == {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci})
                else $error("R5 group selection wrong");
        end
    end
endmodule

// File: rtl/csa_bec_adder.sv
module csa_bec_adder #(
    parameter int unsigned N         = 16,
    parameter int unsigned NGRP      = 4,
    parameter logic [8*NGRP-1:0] GRP_SIZES = {8'd4, 8'd4, 8'd4, 8'd4}
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         carry_i,
    output logic [N-1:0] sum_o,
    output logic         carry_o
);
    import csa_pkg::*;

    localparam logic [8*MAX_GROUPS-1:0] SZ = (8*MAX_GROUPS)'(GRP_SIZES);
    localparam int unsigned TOTAL = grp_off(SZ, NGRP);

    if (TOTAL != N || NGRP > MAX_GROUPS) begin : g_bad_sizes
        $error("R6: group widths add to %0d, expected %0d", TOTAL, N);
    end

    logic [NGRP:0] gc;
    assign gc[0] = carry_i;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int unsigned LO = grp_off(SZ, g);
        localparam int unsigned W  = int'(GRP_SIZES[8*g +: 8]);
        if (g == 0) begin : g_base
            csa_ripple #(.W(W)) u_base (
                .a(op_a[LO +: W]), .b(op_b[LO +: W]), .ci(gc[g]),
                .s(sum_o[LO +: W]), .co(gc[g+1])
            );
        end else begin : g_sel
            csa_sel_group #(.W(W)) u_sel (
                .a(op_a[LO +: W]), .b(op_b[LO +: W]), .ci(gc[g]),
                .s(sum_o[LO +: W]), .co(gc[g+1])
            );
        end
    end

    assign carry_o = gc[NGRP];

    always_comb begin : chk
        if (!$isunknown({op_a, op_b, carry_i, sum_o, carry_o})) begin
            a_r1_total_sum: assert ({carry_o, sum_o} ==
                                    {1'b0, op_a} + {1'b0, op_b} + {{N{1'b0}}, carry_i})
                else $error("R1 adder result wrong");
        end
    end
endmodule

// File: tb/sim_csa_bec_adder.sv
module sim_csa_bec_adder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] a0, b0, s0, a1, b1, s1;
    logic [7:0]  a2, b2, s2;
    logic [31:0] a3, b3, s3;
    logic [63:0] a4, b4, s4;
    logic        ci, c0, c1, c2, c3, c4;

    csa_bec_adder u0 (.op_a(a0), .op_b(b0), .carry_i(ci), .sum_o(s0), .carry_o(c0));
    csa_bec_adder #(.N(16), .NGRP(5), .GRP_SIZES({8'd5, 8'd4, 8'd3, 8'd2, 8'd2})) u1 (
        .op_a(a1), .op_b(b1), .carry_i(ci), .sum_o(s1), .carry_o(c1));
    csa_bec_adder #(.N(8), .NGRP(3), .GRP_SIZES({8'd3, 8'd3, 8'd2})) u2 (
        .op_a(a2), .op_b(b2), .carry_i(ci), .sum_o(s2), .carry_o(c2));
    csa_bec_adder #(.N(32), .NGRP(8), .GRP_SIZES({8{8'd4}})) u3 (
        .op_a(a3), .op_b(b3), .carry_i(ci), .sum_o(s3), .carry_o(c3));
    csa_bec_adder #(.N(64), .NGRP(10),
                    .GRP_SIZES({8'd10, 8'd10, 8'd9, 8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2})) u4 (
        .op_a(a4), .op_b(b4), .carry_i(ci), .sum_o(s4), .carry_o(c4));

    task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive all instances from one 64-bit vector pair, then compare each against a + b + cin.
    task automatic apply(input logic [63:0] va, input logic [63:0] vb, input logic vc,
                         input string req);
        logic [64:0] e;
        @(posedge clk);
        a0 = va[15:0]; b0 = vb[15:0];
        a1 = va[15:0]; b1 = vb[15:0];
        a2 = va[7:0];  b2 = vb[7:0];
        a3 = va[31:0]; b3 = vb[31:0];
        a4 = va;       b4 = vb;
        ci = vc;
        @(negedge clk);
        e = 65'(va[15:0]) + 65'(vb[15:0]) + 65'(vc);
        chk({req, " u0"}, 65'({c0, s0}), e);
        chk({req, " u1 R7"}, 65'({c1, s1}), e);
        e = 65'(va[7:0]) + 65'(vb[7:0]) + 65'(vc);
        chk({req, " u2"}, 65'({c2, s2}), e);
        e = 65'(va[31:0]) + 65'(vb[31:0]) + 65'(vc);
        chk({req, " u3 R9"}, 65'({c3, s3}), e);
        e = {1'b0, va} + {1'b0, vb} + 65'(vc);
        chk({req, " u4 R9"}, 65'({c4, s4}), e);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        a0 = '0; b0 = '0; a1 = '0; b1 = '0; a2 = '0; b2 = '0;
        a3 = '0; b3 = '0; a4 = '0; b4 = '0; ci = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: zero inputs give zero result on every build (R1)
        chk("R1 reset u0", 65'({c0, s0}), 65'd0);
        chk("R1 reset u4", 65'({c4, s4}), 65'd0);

        // R8: carry from bit 0 crosses every group boundary
        apply('1, 64'd1, 1'b0, "R8 ones+1");
        apply('1, 64'd0, 1'b1, "R8 ones+cin");
        apply('1, '1, 1'b1, "R8 ones+ones+cin");
        // R2: lowest group alone, carry stops inside it
        apply(64'h1, 64'h1, 1'b1, "R2 base");
        // R5: carry into group 1 of u0 is 1 while group 1 operands are 0 -> selects incremented
        apply(64'h0F, 64'h01, 1'b0, "R5 sel one");
        apply(64'h0E, 64'h01, 1'b0, "R5 sel zero");
        // R4: group 1 zero-assumed sum all ones, carry-in one -> carry out of group 1
        apply(64'hFF, 64'h01, 1'b0, "R4 full group");
        apply(64'hF0F, 64'h001, 1'b0, "R4 carry stops");
        // R3: increment across alternating patterns
        apply(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, "R3 alt");
        // R6: most significant group placed at the top bits
        apply(64'h8000_0000_0000_8000, 64'h8000_0000_0000_8000, 1'b0, "R6 msb");

        // R1: exhaustive 8-bit build (operands and carry-in), random upper bits for wide builds
        for (int i = 0; i < (1 << 17); i++) begin
            logic [63:0] ra, rb;
            ra = rnd64(); rb = rnd64();
            ra[7:0] = 8'(i);
            rb[7:0] = 8'(i >> 8);
            apply(ra, rb, i[16], "R1 sweep");
        end
        // R9, R7: random wide vectors
        for (int i = 0; i < 2000; i++) begin
            apply(rnd64(), rnd64(), 1'($urandom), "R9 random");
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end
endmodule